// File: doc/BRIEF.md
# Supervisory Reset Generator with Windowed Watchdog

This block produces an active-low reset for a processor subsystem from two causes: a flag that reports whether a monitored supply is above its threshold, and a watchdog that checks when the software services it with falling edges on a service line. Both the supply flag and the service line arrive asynchronously and are brought into the clock domain by two-flop synchronisers. The watchdog timeout and the reset hold time are run-time inputs counted in clock cycles, so firmware or straps can set them without rebuilding the block.

The watchdog has two checking styles. In timeout style, any falling edge that arrives before the period runs out restarts the count. In window style, the period starts with a closed window in which an edge counts as a fault, and continues with an open window in which an edge is accepted. A select input places the end of the closed window at half or at three quarters of the period. Each accepted edge and each fault is reported to downstream logic on a one-cycle strobe. The watchdog is held clear for as long as reset is low and starts again from zero when reset is released.

Top module: `supv_rst_wdog`

## Requirements
- R1: After block reset, and while the synchronised supply flag is low, rst_out_n is 0; raising rst_n leaves rst_out_n low.
- R2: When the supply flag goes high, rst_out_n rises on the (HOLD+2)th clock edge counted from the first edge that samples the flag high (two synchroniser stages, then the hold period), so it is seen low on exactly HOLD+1 falling clock edges after that first sampling edge.
- R3: A watchdog fault drives rst_out_n low in the same cycle that fault_o is high and keeps it low for exactly hold_period_i cycles.
- R4: A hold_period_i of 0 behaves as 1: every reset pulse lasts at least one cycle.
- R5: The watchdog count is 0 throughout a reset pulse, falling edges on svc_i during reset produce neither strobe, and the count restarts from 0 when reset is released; a falling edge while running restarts the count.
- R6: With win_mode_i = 0 (timeout style), a fault occurs when the count reaches tmo_period_i − 1 with no falling edge in that cycle.
- R7: With win_mode_i = 1 (window style), the closed window is floor(P/2) cycles when win_frac_i = 0 and P − floor(P/4) cycles when win_frac_i = 1 (P = tmo_period_i); a falling edge seen while the count is below that length is a fault.
- R8: A falling edge seen while the watchdog runs and that is not an early fault (any edge in timeout style, an open-window edge in window style) raises good_o for one cycle.
- R9: tmo_period_i = 0 disables the watchdog: no fault, no good strobe and no watchdog-caused reset.
- R10: fault_o and good_o are registered, never high together, and each is high for a single cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_ok_i | input | 1 | Asynchronous supply-above-threshold flag, 1 = good |
| svc_i | input | 1 | Asynchronous watchdog service line, falling edges count |
| win_mode_i | input | 1 | 0 = timeout style, 1 = window style |
| win_frac_i | input | 1 | Closed-window end: 0 = half period, 1 = three quarters |
| tmo_period_i | input | CNT_W | Watchdog period in cycles, 0 disables |
| hold_period_i | input | CNT_W | Reset hold time in cycles, 0 treated as 1 |
| rst_out_n | output | 1 | Active-low supervisory reset |
| fault_o | output | 1 | One-cycle strobe on a watchdog fault |
| good_o | output | 1 | One-cycle strobe on an accepted service edge |

## Verification
The bench builds the block with CNT_W = 8 and two synchroniser stages and runs it with periods of 20 cycles and hold times of 5 and 0. Such short periods put late faults, early faults at both window fractions, zero-hold pulses and service edges landing inside a reset pulse within a few hundred cycles, so every window boundary is crossed many times. A behavioural model tracks the input history and the watchdog timing in integers and is compared on every cycle, alongside directed measurements of pulse lengths and strobe counts.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic {
    WD_TIMEOUT = 1'b0,
    WD_WINDOW  = 1'b1
  } wd_mode_e;

  localparam int unsigned SYNC_DEPTH_DFLT = 2;
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[gi] <= RST_VAL;
        else        chain_q[gi] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[gi] <= RST_VAL;
        else        chain_q[gi] <= chain_q[gi-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
  import supv_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             fall_i,
  input  logic             mode_i,
  input  logic             frac_i,
  input  logic [CNT_W-1:0] tmo_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fault_o,
  output logic             good_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // length of the closed window in cycles
  function automatic logic [CNT_W-1:0] closed_len(input logic [CNT_W-1:0] p,
                                                  input logic sel);
    if (sel) closed_len = p - (p >> 2);
    else     closed_len = p >> 1;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             enabled;
  logic             late_ev;
  logic             early_ev;

  always_comb begin
    enabled  = run_i && (tmo_i != '0);
    late_ev  = enabled && !fall_i && (cnt_q >= (tmo_i - ONE));
    early_ev = enabled && fall_i && (mode_i == WD_WINDOW) &&
               (cnt_q < closed_len(tmo_i, frac_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (!enabled || fall_i || late_ev) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + ONE;
  end

  assign cnt_o   = cnt_q;
  assign fault_o = late_ev || early_ev;
  assign good_o  = enabled && fall_i && !early_ev;
endmodule

// File: rtl/supv_rst_hold.sv
module supv_rst_hold #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok_i,
  input  logic             fault_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             rst_act_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // last count value of a pulse; a zero hold still gives one cycle
  function automatic logic [CNT_W-1:0] hold_last(input logic [CNT_W-1:0] h);
    if (h == '0) hold_last = '0;
    else         hold_last = h - ONE;
  endfunction

  logic             act_q;
  logic [CNT_W-1:0] hcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b1;
      hcnt_q <= '0;
    end else if (!supply_ok_i || fault_i) begin
      act_q  <= 1'b1;
      hcnt_q <= '0;
    end else if (act_q) begin
      if (hcnt_q >= hold_last(hold_i)) begin
        act_q  <= 1'b0;
        hcnt_q <= '0;
      end else begin
        hcnt_q <= hcnt_q + ONE;
      end
    end
  end

  assign rst_act_o = act_q;
endmodule

// File: rtl/supv_rst_wdog.sv
module supv_rst_wdog
  import supv_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DFLT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok_i,
  input  logic             svc_i,
  input  logic             win_mode_i,
  input  logic             win_frac_i,
  input  logic [CNT_W-1:0] tmo_period_i,
  input  logic [CNT_W-1:0] hold_period_i,
  output logic             rst_out_n,
  output logic             fault_o,
  output logic             good_o
);
  // named internal events, visible to the bound checker
  logic             sup_s;
  logic             svc_s;
  logic             svc_d;
  logic             svc_fall;
  logic             rst_act;
  logic             wd_fault;
  logic             wd_good;
  logic [CNT_W-1:0] wd_cnt;
  logic             fault_q;
  logic             good_q;

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sup (
    .clk(clk), .rst_n(rst_n), .d_i(supply_ok_i), .q_o(sup_s)
  );

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_svc (
    .clk(clk), .rst_n(rst_n), .d_i(svc_i), .q_o(svc_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_d <= 1'b0;
    else        svc_d <= svc_s;
  end

  assign svc_fall = svc_d && !svc_s;

  supv_wdog #(.CNT_W(CNT_W)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (!rst_act),
    .fall_i  (svc_fall),
    .mode_i  (win_mode_i),
    .frac_i  (win_frac_i),
    .tmo_i   (tmo_period_i),
    .cnt_o   (wd_cnt),
    .fault_o (wd_fault),
    .good_o  (wd_good)
  );

  supv_rst_hold #(.CNT_W(CNT_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok_i (sup_s),
    .fault_i     (wd_fault),
    .hold_i      (hold_period_i),
    .rst_act_o   (rst_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      good_q  <= 1'b0;
    end else begin
      fault_q <= wd_fault;
      good_q  <= wd_good;
    end
  end

  assign rst_out_n = !rst_act;
  assign fault_o   = fault_q;
  assign good_o    = good_q;
endmodule

// File: rtl/supv_rst_wdog_chk.sv
module supv_rst_wdog_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_out_n,
  input logic             fault_o,
  input logic             good_o,
  input logic [CNT_W-1:0] tmo_period_i,
  input logic [CNT_W-1:0] wd_cnt
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_o && good_o));

  // R10
  fault_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o);

  // R10
  good_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_o |=> !good_o);

  // R3
  fault_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !rst_out_n);

  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out_n && $past(!rst_out_n)) |-> (wd_cnt == '0));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmo_period_i) == '0) |-> (!fault_o && !good_o));
endmodule

bind supv_rst_wdog supv_rst_wdog_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_out_n    (rst_out_n),
  .fault_o      (fault_o),
  .good_o       (good_o),
  .tmo_period_i (tmo_period_i),
  .wd_cnt       (wd_cnt)
);

// File: tb/supv_rst_wdog_tb_top.sv
module supv_rst_wdog_tb_top;
  localparam int unsigned CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          supply_ok_i = 1'b0;
  logic          svc_i = 1'b1;
  logic          win_mode_i = 1'b0;
  logic          win_frac_i = 1'b0;
  logic [CW-1:0] tmo_period_i = 8'd20;
  logic [CW-1:0] hold_period_i = 8'd5;
  logic          rst_out_n;
  logic          fault_o;
  logic          good_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int dut_faults = 0;
  int dut_goods = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  supv_rst_wdog #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok_i), .svc_i(svc_i),
    .win_mode_i(win_mode_i), .win_frac_i(win_frac_i),
    .tmo_period_i(tmo_period_i), .hold_period_i(hold_period_i),
    .rst_out_n(rst_out_n), .fault_o(fault_o), .good_o(good_o)
  );

  // ---------------- behavioural reference ----------------
  int sv_hist[$];
  int sp_hist[$];
  int m_act, m_h, m_w, m_fault, m_good;

  always @(posedge clk) begin
    if (!rst_n) begin
      sv_hist = {0, 0, 0, 0};
      sp_hist = {0, 0, 0, 0};
      m_act = 1; m_h = 0; m_w = 0; m_fault = 0; m_good = 0;
    end else begin
      int tmo, hold, closed, fall, sup, flt, gd;
      sv_hist.push_front(int'(svc_i));       void'(sv_hist.pop_back());
      sp_hist.push_front(int'(supply_ok_i)); void'(sp_hist.pop_back());
      fall = (sv_hist[3] == 1 && sv_hist[2] == 0) ? 1 : 0;
      sup  = sp_hist[2];
      tmo  = int'(tmo_period_i);
      hold = (hold_period_i == 0) ? 1 : int'(hold_period_i);
      closed = win_frac_i ? (tmo - tmo / 4) : (tmo / 2);
      flt = 0; gd = 0;
      if (m_act == 0 && tmo != 0) begin
        if (fall == 1) begin
          if (win_mode_i && m_w < closed) flt = 1; else gd = 1;
          m_w = 0;
        end else if (m_w >= tmo - 1) begin
          flt = 1; m_w = 0;
        end else m_w = m_w + 1;
      end else m_w = 0;
      if (sup == 0 || flt == 1) begin
        m_act = 1; m_h = 0;
      end else if (m_act == 1) begin
        if (m_h >= hold - 1) begin m_act = 0; m_h = 0; end
        else m_h = m_h + 1;
      end
      m_fault = flt; m_good = gd;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      if (fault_o) dut_faults++;
      if (good_o)  dut_goods++;
      check(cur_req, "rst_out_n", int'(rst_out_n), 1 - m_act);
      check(cur_req, "fault_o",   int'(fault_o),   m_fault);
      check(cur_req, "good_o",    int'(good_o),    m_good);
    end
    if (cyc > 20000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d expected <= 20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick();
    svc_i = 1'b0; tick(2); svc_i = 1'b1;
  endtask

  task automatic wait_fault(input string req);
    int k = 0;
    while (!fault_o && k < 200) begin tick(1); k++; end
    check(req, "fault seen within limit", int'(fault_o), 1);
  endtask

  task automatic low_len(output int n);
    n = 0;
    while (!rst_out_n && n < 500) begin n++; tick(1); end
  endtask

  initial begin
    int n, f0, g0;
    tick(3);
    // R1: reset state
    check("R1", "rst_out_n in reset", int'(rst_out_n), 0);
    check("R1", "fault_o in reset", int'(fault_o), 0);
    check("R1", "good_o in reset", int'(good_o), 0);
    rst_n = 1'b1;
    tick(6);
    check("R1", "rst_out_n with supply low", int'(rst_out_n), 0);

    // R2: release delay after supply good
    cur_req = "R2";
    supply_ok_i = 1'b1;
    tick(1); low_len(n);
    check("R2", "low cycles after supply high", n, 5 + 1);

    // R8: timeout style, regular service
    cur_req = "R8";
    g0 = dut_goods; f0 = dut_faults;
    for (int i = 0; i < 4; i++) begin tick(8); kick(); end
    tick(4);
    check("R8", "good strobes for 4 kicks", dut_goods - g0, 4);
    check("R8", "no fault with regular kicks", dut_faults - f0, 0);

    // R6 / R3: late fault and hold length
    cur_req = "R6";
    wait_fault("R6");
    cur_req = "R3";
    check("R3", "reset low with fault strobe", int'(rst_out_n), 0);
    g0 = dut_goods;
    svc_i = 1'b0; tick(1); svc_i = 1'b1;   // edge inside reset pulse
    n = 1; low_len(f0); n = n + f0;
    check("R3", "reset pulse length", n, 5);
    cur_req = "R5";
    tick(3);
    check("R5", "edge during reset ignored", dut_goods - g0, 0);

    // R7: window style, half-period closed window
    cur_req = "R7";
    win_mode_i = 1'b1; win_frac_i = 1'b0;
    wait_fault("R6"); tick(1); low_len(n);
    f0 = dut_faults; g0 = dut_goods;
    kick(); tick(4);
    check("R7", "early edge faults (half)", dut_faults - f0, 1);
    low_len(n);
    tick(11); kick(); tick(4);
    check("R8", "open-window edge good", dut_goods - g0, 1);
    // three-quarter closed window
    win_frac_i = 1'b1;
    f0 = dut_faults;
    tick(6); kick(); tick(4);
    check("R7", "early edge faults (3/4)", dut_faults - f0, 1);
    low_len(n);

    // R4: zero hold
    cur_req = "R4";
    win_mode_i = 1'b0; hold_period_i = 8'd0;
    wait_fault("R6");
    n = 1; tick(1); low_len(f0); n = n + f0;
    check("R4", "zero hold pulse length", n, 1);

    // R9: disabled
    cur_req = "R9";
    hold_period_i = 8'd5;
    tmo_period_i = 8'd0;
    f0 = dut_faults; g0 = dut_goods;
    tick(150); kick(); tick(20);
    check("R9", "no faults when disabled", dut_faults - f0, 0);
    check("R9", "no goods when disabled", dut_goods - g0, 0);
    check("R9", "reset stays high when disabled", int'(rst_out_n), 1);

    // R1: supply drop during operation
    cur_req = "R1";
    tmo_period_i = 8'd20;
    tick(5); kick();
    supply_ok_i = 1'b0;
    tick(4);
    check("R1", "reset low after supply drop", int'(rst_out_n), 0);
    tick(30);
    check("R1", "reset held while supply low", int'(rst_out_n), 0);
    cur_req = "R10";
    supply_ok_i = 1'b1;
    tick(60);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule